// File: doc/BRIEF.md
# Physical Memory Protection Checker

This block decides, for every physical memory access, whether the access may read, write or execute. It keeps a parameterised set of protection entries. Each entry has a configuration byte and a word-granular address register, and both are loaded through a single register write port. An access presents its byte address, its size as the log2 of its byte count, and the privilege mode of the requester. The block answers with three allow bits in the same cycle.

Each entry describes a region in one of three encodings: a range bounded by the previous entry's address and its own (top of range), a single aligned 4-byte word, or an aligned power-of-two block whose size is read from the trailing ones of the address register. Entries are searched in index order. An access that starts inside a region but runs past its end is refused outright. Machine mode is trusted unless an entry is locked, and less privileged modes get only what an entry grants. A lock also freezes the entry's registers until reset.

Top module: `pmp_access_check`

## Requirements
- R1: Writes with `csr_we` high load entry `csr_idx` at the clock edge; `csr_sel`=0 loads the configuration byte from `csr_wdata[7:0]` (bit 0 read, bit 1 write, bit 2 execute, bits 4:3 mode with 0 off, 1 top-of-range, 2 4-byte, 3 power-of-two, bit 7 lock), `csr_sel`=1 loads the address register, which holds byte address bits [PA_WIDTH-1:2]; an index at or above `NUM_ENTRIES` (0 to 16) changes nothing.
- R2: An access matched by no entry gets all three allow bits in machine mode (`acc_priv`=3) and none in any other mode.
- R3: When several entries match, the lowest-numbered one alone decides the result; an entry in mode off never matches.
- R4: A top-of-range entry i covers bytes from address register i-1 times 4 (0 for entry 0) up to, but not including, address register i times 4.
- R5: A 4-byte entry covers the four bytes starting at its address register times 4.
- R6: A power-of-two entry whose address register ends in k one bits covers 2^(k+3) bytes aligned to that size; an all-ones register covers the whole space.
- R7: An access whose first byte lies in the deciding entry's region but whose last byte (address plus 2^size minus 1, possibly beyond the top of the address space) does not is refused all three permissions and does not fall through to later entries.
- R8: In machine mode a deciding entry that is unlocked allows everything, and a locked one allows exactly its read, write and execute flags.
- R9: Below machine mode the deciding entry's flags are the result whether or not it is locked; no permission exists without a deciding entry.
- R10: A locked entry ignores writes to its configuration and address registers until reset; reset clears every entry to off, unlocked, address zero, after which entries are writable again.
- R11: If entry i+1 is locked and in top-of-range mode, writes to address register i are ignored.
- R12: The allow bits follow the access inputs and the current register state combinationally; after reset all entries are off.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_we | input | 1 | Register write strobe |
| csr_sel | input | 1 | 0 selects configuration byte, 1 selects address register |
| csr_idx | input | 4 | Entry index of the write |
| csr_wdata | input | PA_WIDTH-2 | Write data |
| acc_addr | input | PA_WIDTH | Byte address of the access |
| acc_size | input | SIZE_W | Log2 of the access size in bytes |
| acc_priv | input | 2 | Privilege mode, 3 is machine |
| allow_r | output | 1 | Read permitted |
| allow_w | output | 1 | Write permitted |
| allow_x | output | 1 | Execute permitted |

## Verification
The properties assume that `acc_priv`, `acc_addr` and `acc_size` stay steady around each rising edge, since the allow bits are combinational and are sampled there; the bench changes them only on falling edges. The lock properties assume that reset is held for at least two edges before any write, so that the register history they compare against is defined, and the bench starts with a longer reset. Writes are also issued only on falling edges, so each one lands at exactly one rising edge.

// File: rtl/pmp_pkg.sv
package pmp_pkg;

  localparam int MAX_ENTRIES = 16;
  localparam int IDX_W       = $clog2(MAX_ENTRIES);

  localparam logic [1:0] PRIV_MACHINE = 2'b11;

  typedef enum logic [1:0] {
    AM_OFF   = 2'd0,
    AM_TOR   = 2'd1,
    AM_NA4   = 2'd2,
    AM_NAPOT = 2'd3
  } amode_e;

  // Stored form of one configuration byte (reserved bits dropped)
  typedef struct packed {
    logic   lock;
    amode_e mode;
    logic   x;
    logic   w;
    logic   r;
  } ecfg_t;

  typedef struct packed {
    logic r;
    logic w;
    logic x;
  } perm_t;

endpackage

// File: rtl/pmp_regfile.sv
module pmp_regfile
  import pmp_pkg::*;
#(
  parameter int N_ENT = 8,
  parameter int NE    = 8,
  parameter int AW    = 30
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  we,
  input  logic                  sel,
  input  logic [IDX_W-1:0]      idx,
  input  logic [AW-1:0]         wdata,
  output ecfg_t [NE-1:0]        cfg_q,
  output logic  [NE-1:0][AW-1:0] addr_q
);

  ecfg_t cfg_d;
  assign cfg_d = '{lock: wdata[7], mode: amode_e'(wdata[4:3]),
                   x: wdata[2], w: wdata[1], r: wdata[0]};

  for (genvar g = 0; g < NE; g++) begin : g_ent
    // A locked top-of-range neighbour above freezes this address register
    logic guard_next;
    if (g + 1 < NE) begin : g_nx
      assign guard_next = cfg_q[g+1].lock && (cfg_q[g+1].mode == AM_TOR);
    end else begin : g_top
      assign guard_next = 1'b0;
    end

    if (g < N_ENT) begin : g_live
      ecfg_t         c_q;
      logic [AW-1:0] a_q;
      logic          sel_me;
      assign sel_me = we && (idx == IDX_W'(g));

      always_ff @(posedge clk) begin
        if (rst) begin
          c_q <= '0;
          a_q <= '0;
        end else if (sel_me && !c_q.lock) begin
          if (!sel)
            c_q <= cfg_d;
          else if (!guard_next)
            a_q <= wdata;
        end
      end

      assign cfg_q[g]  = c_q;
      assign addr_q[g] = a_q;
    end else begin : g_dead
      assign cfg_q[g]  = '0;
      assign addr_q[g] = '0;
    end
  end

endmodule

// File: rtl/pmp_match.sv
module pmp_match
  import pmp_pkg::*;
#(
  parameter int PA = 32,
  parameter int AW = 30
) (
  input  amode_e        mode,
  input  logic [AW-1:0] this_addr,
  input  logic [AW-1:0] prev_addr,
  input  logic [PA:0]   first_b,
  input  logic [PA:0]   last_b,
  output logic          hit,
  output logic          partial
);

  // Byte bounds for top-of-range, one extra bit so the top never wraps
  logic [PA:0] tor_lo, tor_hi;
  assign tor_lo = {1'b0, prev_addr, 2'b00};
  assign tor_hi = {1'b0, this_addr, 2'b00};

  // Word views of the access ends (carry bit kept)
  logic [AW:0] first_w, last_w;
  assign first_w = first_b[PA:2];
  assign last_w  = last_b[PA:2];

  // Trailing ones plus the next zero mark the don't-care word bits
  logic [AW-1:0] run;
  logic [AW:0]   care, base_w;
  assign run    = this_addr ^ (this_addr + 1'b1);
  assign care   = {1'b1, ~run};
  assign base_w = {1'b0, this_addr};

  logic first_in, last_in;
  always_comb begin
    case (mode)
      AM_TOR: begin
        first_in = (first_b >= tor_lo) && (first_b < tor_hi);
        last_in  = (last_b  >= tor_lo) && (last_b  < tor_hi);
      end
      AM_NA4: begin
        first_in = (first_w == base_w);
        last_in  = (last_w  == base_w);
      end
      AM_NAPOT: begin
        first_in = ((first_w ^ base_w) & care) == '0;
        last_in  = ((last_w  ^ base_w) & care) == '0;
      end
      default: begin
        first_in = 1'b0;
        last_in  = 1'b0;
      end
    endcase
  end

  assign hit     = first_in;
  assign partial = first_in && !last_in;

endmodule

// File: rtl/pmp_resolve.sv
module pmp_resolve
  import pmp_pkg::*;
#(
  parameter int NE = 8
) (
  input  logic [NE-1:0]      hit,
  input  logic [NE-1:0]      partial,
  input  logic [NE-1:0][3:0] flags,   // {lock, r, w, x}
  input  logic [1:0]         priv,
  output perm_t              perm,
  output logic               any_hit,
  output logic               sel_partial
);

  logic       found;
  logic       w_part;
  logic [3:0] w_flags;

  // Scan from the top so the lowest-numbered hit is the last one kept
  always_comb begin
    found   = 1'b0;
    w_part  = 1'b0;
    w_flags = '0;
    for (int i = NE - 1; i >= 0; i--) begin
      if (hit[i]) begin
        found   = 1'b1;
        w_part  = partial[i];
        w_flags = flags[i];
      end
    end
  end

  logic is_m;
  assign is_m = (priv == PRIV_MACHINE);

  always_comb begin
    if (!found)
      perm = is_m ? '1 : '0;
    else if (w_part)
      perm = '0;
    else if (is_m && !w_flags[3])
      perm = '1;
    else
      perm = '{r: w_flags[2], w: w_flags[1], x: w_flags[0]};
  end

  assign any_hit     = found;
  assign sel_partial = found && w_part;

endmodule

// File: rtl/pmp_access_check.sv
module pmp_access_check
  import pmp_pkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  parameter int PA_WIDTH    = 32,
  parameter int SIZE_W      = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                csr_we,
  input  logic                csr_sel,
  input  logic [IDX_W-1:0]    csr_idx,
  input  logic [PA_WIDTH-3:0] csr_wdata,
  input  logic [PA_WIDTH-1:0] acc_addr,
  input  logic [SIZE_W-1:0]   acc_size,
  input  logic [1:0]          acc_priv,
  output logic                allow_r,
  output logic                allow_w,
  output logic                allow_x
);

  localparam int NE = (NUM_ENTRIES == 0) ? 1 : NUM_ENTRIES;
  localparam int AW = PA_WIDTH - 2;

  ecfg_t [NE-1:0]         cfg_q;
  logic  [NE-1:0][AW-1:0] addr_q;
  logic  [NE-1:0][AW-1:0] prev_q;
  logic  [NE-1:0]         hit_v;
  logic  [NE-1:0]         part_v;
  logic  [NE-1:0][3:0]    flag_v;
  logic                   any_hit;
  logic                   sel_partial;
  perm_t                  perm;

  pmp_regfile #(.N_ENT(NUM_ENTRIES), .NE(NE), .AW(AW)) u_regs (
    .clk    (clk),
    .rst    (rst),
    .we     (csr_we),
    .sel    (csr_sel),
    .idx    (csr_idx),
    .wdata  (csr_wdata),
    .cfg_q  (cfg_q),
    .addr_q (addr_q)
  );

  // First and last byte of the access, one bit wider than the space
  logic [PA_WIDTH:0] first_b, last_b;
  assign first_b = {1'b0, acc_addr};
  assign last_b  = first_b + (((PA_WIDTH+1)'(1)) << acc_size) - (PA_WIDTH+1)'(1);

  for (genvar g = 0; g < NE; g++) begin : g_chk
    if (g == 0) begin : g_base0
      assign prev_q[g] = '0;
    end else begin : g_baseN
      assign prev_q[g] = addr_q[g-1];
    end

    assign flag_v[g] = {cfg_q[g].lock, cfg_q[g].r, cfg_q[g].w, cfg_q[g].x};

    if (g < NUM_ENTRIES) begin : g_live
      pmp_match #(.PA(PA_WIDTH), .AW(AW)) u_match (
        .mode      (cfg_q[g].mode),
        .this_addr (addr_q[g]),
        .prev_addr (prev_q[g]),
        .first_b   (first_b),
        .last_b    (last_b),
        .hit       (hit_v[g]),
        .partial   (part_v[g])
      );
    end else begin : g_dead
      assign hit_v[g]  = 1'b0;
      assign part_v[g] = 1'b0;
    end
  end

  pmp_resolve #(.NE(NE)) u_resolve (
    .hit         (hit_v),
    .partial     (part_v),
    .flags       (flag_v),
    .priv        (acc_priv),
    .perm        (perm),
    .any_hit     (any_hit),
    .sel_partial (sel_partial)
  );

  assign allow_r = perm.r;
  assign allow_w = perm.w;
  assign allow_x = perm.x;

endmodule

// File: rtl/pmp_access_check_sva.sv
module pmp_access_check_sva
  import pmp_pkg::*;
#(
  parameter int NE = 8,
  parameter int AW = 30
) (
  input logic                  clk,
  input logic                  rst,
  input logic [1:0]            acc_priv,
  input logic                  allow_r,
  input logic                  allow_w,
  input logic                  allow_x,
  input logic                  any_hit,
  input logic                  sel_partial,
  input ecfg_t [NE-1:0]        cfg_q,
  input logic  [NE-1:0][AW-1:0] addr_q
);

  assert_default_machine_R2: assert property (@(posedge clk) disable iff (rst)
    (!any_hit && acc_priv == PRIV_MACHINE) |-> (allow_r && allow_w && allow_x));

  assert_default_lower_R2: assert property (@(posedge clk) disable iff (rst)
    (!any_hit && acc_priv != PRIV_MACHINE) |-> !(allow_r || allow_w || allow_x));

  assert_partial_denied_R7: assert property (@(posedge clk) disable iff (rst)
    sel_partial |-> !(allow_r || allow_w || allow_x));

  assert_lower_needs_entry_R9: assert property (@(posedge clk) disable iff (rst)
    (acc_priv != PRIV_MACHINE && (allow_r || allow_w || allow_x)) |-> (any_hit && !sel_partial));

  for (genvar g = 0; g < NE; g++) begin : g_prop
    assert_locked_frozen_R10: assert property (@(posedge clk) disable iff (rst)
      $past(cfg_q[g].lock) |-> ($stable(cfg_q[g]) && $stable(addr_q[g])));

    if (g + 1 < NE) begin : g_guard
      assert_tor_guard_R11: assert property (@(posedge clk) disable iff (rst)
        $past(cfg_q[g+1].lock && cfg_q[g+1].mode == AM_TOR) |-> $stable(addr_q[g]));
    end
  end

endmodule

bind pmp_access_check pmp_access_check_sva #(.NE(NE), .AW(AW)) u_sva (
  .clk         (clk),
  .rst         (rst),
  .acc_priv    (acc_priv),
  .allow_r     (allow_r),
  .allow_w     (allow_w),
  .allow_x     (allow_x),
  .any_hit     (any_hit),
  .sel_partial (sel_partial),
  .cfg_q       (cfg_q),
  .addr_q      (addr_q)
);

// File: tb/test_pmp_access_check.sv
`timescale 1ns / 1ps
module test_pmp_access_check;

  localparam int PA = 32;
  localparam int AW = PA - 2;
  localparam logic [1:0] PU = 2'd0, PS = 2'd1, PM = 2'd3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          csr_we = 1'b0;
  logic          csr_sel = 1'b0;
  logic [3:0]    csr_idx = '0;
  logic [AW-1:0] csr_wdata = '0;
  logic [PA-1:0] acc_addr = '0;
  logic [1:0]    acc_size = '0;
  logic [1:0]    acc_priv = '0;
  logic          allow_r, allow_w, allow_x;

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 1'b0;

  always #2.5 clk = ~clk;

  pmp_access_check #(.NUM_ENTRIES(8), .PA_WIDTH(PA), .SIZE_W(2)) i_pmp_access_check (
    .clk (clk), .rst (rst), .csr_we (csr_we), .csr_sel (csr_sel),
    .csr_idx (csr_idx), .csr_wdata (csr_wdata), .acc_addr (acc_addr),
    .acc_size (acc_size), .acc_priv (acc_priv),
    .allow_r (allow_r), .allow_w (allow_w), .allow_x (allow_x)
  );

  // {addr[31:0], size[1:0], priv[1:0], expected rwx[2:0], requirement[3:0]}
  localparam int NV = 25;
  localparam logic [42:0] VEC [NV] = '{
    {32'h0000_0100, 2'd2, PU, 3'b100, 4'd9 },  // R9 unlocked flags below M
    {32'h0000_0100, 2'd2, PM, 3'b111, 4'd8 },  // R8 unlocked in M
    {32'h0000_0FFC, 2'd2, PU, 3'b100, 4'd4 },  // R4 last word of TOR
    {32'h0000_0FFE, 2'd2, PU, 3'b000, 4'd7 },  // R7 straddles TOR top
    {32'h0000_0FFE, 2'd2, PM, 3'b000, 4'd7 },  // R7 also in M
    {32'h0000_2000, 2'd2, PU, 3'b110, 4'd5 },  // R5 4-byte entry
    {32'h0000_2000, 2'd2, PM, 3'b110, 4'd8 },  // R8 locked in M
    {32'h0000_2004, 2'd0, PU, 3'b000, 4'd2 },  // R2 no match, user
    {32'h0000_2004, 2'd0, PM, 3'b111, 4'd2 },  // R2 no match, machine
    {32'h0000_2002, 2'd2, PS, 3'b000, 4'd7 },  // R7 straddles 4-byte entry
    {32'h0000_4010, 2'd3, PU, 3'b001, 4'd3 },  // R3 entry 2 beats entry 3
    {32'h0000_4010, 2'd3, PM, 3'b111, 4'd8 },  // R8 unlocked entry 2
    {32'h0000_40F8, 2'd3, PU, 3'b001, 4'd6 },  // R6 256-byte top doubleword
    {32'h0000_40FC, 2'd3, PU, 3'b000, 4'd7 },  // R7 no fall-through to entry 3
    {32'h0000_4800, 2'd1, PS, 3'b110, 4'd6 },  // R6 4 KiB block
    {32'h0000_4800, 2'd1, PM, 3'b110, 4'd8 },  // R8 locked block in M
    {32'h0000_4FFF, 2'd0, PU, 3'b110, 4'd6 },  // R6 last byte of block
    {32'h0000_5000, 2'd0, PU, 3'b000, 4'd6 },  // R6 just past block
    {32'h0000_C000, 2'd2, PU, 3'b101, 4'd4 },  // R4 TOR lower bound from entry 4
    {32'h0000_FFFC, 2'd2, PS, 3'b101, 4'd4 },  // R4 TOR upper word
    {32'h0000_BFFC, 2'd2, PU, 3'b000, 4'd4 },  // R4 below TOR base
    {32'h0001_0000, 2'd0, PM, 3'b111, 4'd2 },  // R2 above TOR top
    {32'h0000_8000, 2'd0, PS, 3'b000, 4'd3 },  // R3 off entry never matches
    {32'hFFFF_FFFC, 2'd3, PM, 3'b111, 4'd2 },  // R2 top of space
    {32'h0000_0000, 2'd0, PU, 3'b100, 4'd4 }   // R4 entry 0 base is zero
  };

  task automatic wr(input bit sel, input int idx, input logic [AW-1:0] d);
    @(negedge clk);
    csr_we    = 1'b1;
    csr_sel   = sel;
    csr_idx   = 4'(idx);
    csr_wdata = d;
    @(negedge clk);
    csr_we    = 1'b0;
  endtask

  task automatic acc(input logic [31:0] a, input logic [1:0] s, input logic [1:0] p);
    @(negedge clk);
    acc_addr = a;
    acc_size = s;
    acc_priv = p;
    #1;
  endtask

  task automatic chk(input string req, input logic [2:0] exp);
    logic [2:0] got;
    got = {allow_r, allow_w, allow_x};
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s addr=%h size=%0d priv=%0d: actual %b expected %b",
               req, acc_addr, acc_size, acc_priv, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R12 reset state: all entries off
    acc(32'h0000_0100, 2'd2, PU); chk("R12 reset user", 3'b000);
    acc(32'h0000_0100, 2'd2, PM); chk("R12 reset machine", 3'b111);

    // R1 setup: address registers first, then configuration bytes
    wr(1'b1, 0, 30'h0000_0400); wr(1'b0, 0, 30'h09);  // TOR [0,0x1000) R
    wr(1'b1, 1, 30'h0000_0800); wr(1'b0, 1, 30'h93);  // 4-byte 0x2000 RW locked
    wr(1'b1, 2, 30'h0000_101F); wr(1'b0, 2, 30'h1C);  // 256 B at 0x4000 X
    wr(1'b1, 3, 30'h0000_11FF); wr(1'b0, 3, 30'h9B);  // 4 KiB at 0x4000 RW locked
    wr(1'b1, 4, 30'h0000_3000); wr(1'b0, 4, 30'h07);  // off
    wr(1'b1, 5, 30'h0000_4000); wr(1'b0, 5, 30'h8D);  // TOR [0xC000,0x10000) RX locked

    for (int i = 0; i < NV; i++) begin
      logic [42:0] v;
      v = VEC[i];
      acc(v[42:11], v[10:9], v[8:7]);
      chk($sformatf("R%0d row %0d", v[3:0], i), v[6:4]);
    end

    // R10 locked entry ignores configuration and address writes
    wr(1'b0, 1, 30'h1F);
    acc(32'h0000_2000, 2'd2, PU); chk("R10 locked cfg write", 3'b110);
    wr(1'b1, 1, 30'h0000_0900);
    acc(32'h0000_2000, 2'd2, PU); chk("R10 locked addr write", 3'b110);

    // R11 locked TOR entry 5 protects address register 4
    wr(1'b1, 4, 30'h0);
    acc(32'h0000_8000, 2'd2, PU); chk("R11 guarded lower bound", 3'b000);
    acc(32'h0000_C000, 2'd2, PU); chk("R11 region intact", 3'b101);

    // R1 unlocked entry stays writable
    wr(1'b1, 0, 30'h0000_0800);
    acc(32'h0000_1800, 2'd2, PU); chk("R1 addr rewrite", 3'b100);
    wr(1'b0, 0, 30'h0F);
    acc(32'h0000_1800, 2'd2, PU); chk("R1 cfg rewrite", 3'b111);

    // R1 index beyond the entry count does nothing
    wr(1'b1, 9, 30'h3FFF_FFFF); wr(1'b0, 9, 30'h1F);
    acc(32'h0000_8000, 2'd0, PU); chk("R1 out-of-range index", 3'b000);

    // R6 all-ones power-of-two covers the whole space
    wr(1'b1, 7, 30'h3FFF_FFFF); wr(1'b0, 7, 30'h19);
    acc(32'h0000_8000, 2'd0, PU); chk("R6 whole space", 3'b100);
    acc(32'hFFFF_FFFC, 2'd2, PU); chk("R6 top word", 3'b100);
    acc(32'hFFFF_FFFC, 2'd3, PU); chk("R7 beyond address space", 3'b000);

    // R10 reset clears locks, entries writable again
    do_reset();
    acc(32'h0000_2000, 2'd2, PU); chk("R10 after reset", 3'b000);
    wr(1'b0, 1, 30'h13);
    acc(32'h0000_0000, 2'd2, PU); chk("R10 writable after reset", 3'b110);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R12 watchdog: actual still running, expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule